// File: doc/BRIEF.md
# E1 CAS Receive Signaling Controller

This block sits behind an E1 receive framer and pulls channel associated signaling out of time slot 16. It takes the received line as a bit stream with a per-bit enable and a strobe that marks the first bit of each 125 µs frame. It counts bit positions itself and collects the eight TS16 bits of every frame into a byte. Every other time slot passes by untouched.

From the TS16 bytes it finds the 16-frame (2 ms) signaling multiframe and follows it. It flags loss of that alignment, a TS16 alarm indication signal, and the remote multiframe alarm bit, and it keeps the three spare service bits as their own status. The ABCD nibbles arrive two channels per frame. They are stored as one byte per frame in a 16-entry register file whose index is the frame number inside the multiframe.

Register updates stop while alignment is lost. They resume only after one full multiframe has followed the regained alignment word. A sticky change flag tells the processor that at least one stored signaling byte took a new value, so it need not scan all sixteen registers every multiframe. A plain combinational read port exposes the registers and a status byte. Reading the status byte clears the flag.

Top module: `e1_cas_rx`

## Requirements
- R1: Only the eight bits at frame positions 128 to 135 (counted from 0 at the bit where `rx_fsync` is high, and only on cycles with `rx_en` high) are used. The values of all other bit positions have no effect on any output.
- R2: The first TS16 bit received lands in byte bit 7. In an aligned, unfrozen state, register k (k = 1..15) holds the TS16 byte of frame k of the multiframe. Register 0 holds the last accepted alignment byte, where frame 0 is the frame carrying the alignment word.
- R3: While unaligned, alignment is taken at the first TS16 byte whose bits 7:4 are 0000, provided the previous TS16 byte had at least one bit set. `mf_lost` then goes low. From reset the previous byte counts as all-zero.
- R4: While aligned, one TS16 byte in frame 0 with bits 7:4 not equal to 0000 keeps alignment. A second such byte in the next frame 0 sets `mf_lost`.
- R5: At each accepted alignment byte, `rmf_alarm` takes byte bit 2 and `spare` takes {bit 3, bit 1, bit 0}.
- R6: TS16 bytes are grouped into windows of 16, counted from reset. `ts16_ais` rises at the end of the second consecutive window that holds fewer than 4 zero bits. It falls at the end of any window with 4 or more zero bits.
- R7: `freeze` is high whenever alignment is lost. After alignment is regained it stays high until the next correct alignment byte in frame 0. No register changes while `freeze` is high.
- R8: The change flag `sig_irq` is set when a write to registers 1..15 changes the stored value. Rewriting an equal value leaves it unchanged. A read of address 16 clears it, and a new set in the same cycle wins over the clear.
- R9: `rd_data` shows register `rd_addr` for addresses 0..15. For address 16 it shows the status byte {mf_lost, freeze, ts16_ais, rmf_alarm, spare[2:0], sig_irq} from bit 7 down to bit 0. For addresses 17..31 it shows 0.
- R10: After reset `mf_lost` and `freeze` are 1, `ts16_ais`, `rmf_alarm`, `spare` and `sig_irq` are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Received bit valid this cycle |
| rx_fsync | input | 1 | Marks bit 0 of a frame (with rx_en) |
| rx_bit | input | 1 | Received data bit |
| rd_en | input | 1 | Read strobe; clears the change flag when reading address 16 |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, combinational |
| mf_lost | output | 1 | Multiframe alignment lost |
| freeze | output | 1 | Register updates blocked |
| ts16_ais | output | 1 | TS16 alarm indication signal |
| rmf_alarm | output | 1 | Remote multiframe alarm bit |
| spare | output | 3 | Spare service bits |
| sig_irq | output | 1 | Stored signaling changed since last status read |

## Verification
The bench sends a zero byte right after reset, which a design that starts with the previous-byte state set would wrongly align on. It sends frame-1 data during the frozen multiframe that follows regained alignment; a design that lifts the freeze at the regain itself would store that data. It sends one bad alignment byte on its own, which a single-error loss rule would treat as lost alignment. It repeats identical multiframes with different filler in the other slots, which exposes a flag that fires on every write or a slot decoder that reads the wrong bits. It places TS16 AIS windows on exact 16-byte boundaries, so a window count that is off by one, or an AIS that sets after one low window, shows up at the first or second boundary.

// File: rtl/e1_cas_rx.sv
module e1_cas_rx #(
  parameter int SLOTS    = 32,
  parameter int SIG_SLOT = 16,
  parameter int MF_LEN   = 16,
  parameter int AIS_ZMIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_fsync,
  input  logic       rx_bit,
  input  logic       rd_en,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       mf_lost,
  output logic       freeze,
  output logic       ts16_ais,
  output logic       rmf_alarm,
  output logic [2:0] spare,
  output logic       sig_irq
);
  localparam int FBITS = SLOTS * 8;
  localparam int PW    = $clog2(FBITS);
  localparam int FIRST = SIG_SLOT * 8;
  localparam int LAST  = FIRST + 7;
  localparam int IW    = $clog2(MF_LEN);
  localparam int ZW    = $clog2(AIS_ZMIN) + 2;

  logic [PW-1:0] pos_q, pos_cur;
  logic [6:0]    sh;
  logic [7:0]    byte_in;
  logic          tick, in_sig, mfas_ok;

  assign pos_cur = rx_fsync ? '0 : pos_q;
  assign in_sig  = (pos_cur >= PW'(FIRST)) && (pos_cur <= PW'(LAST));
  assign tick    = rx_en && (pos_cur == PW'(LAST));
  assign byte_in = {sh, rx_bit};
  assign mfas_ok = (byte_in[7:4] == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      sh    <= '0;
    end else if (rx_en) begin
      pos_q <= (pos_cur == PW'(FBITS - 1)) ? '0 : pos_cur + 1'b1;
      if (in_sig) sh <= {sh[5:0], rx_bit};
    end
  end

  // TS16 AIS: zero-bit count per window of MF_LEN bytes
  logic [IW-1:0] wcnt;
  logic [ZW-1:0] zacc, zsum;
  logic          low_run, win_low;

  assign zsum    = zacc + ZW'(8 - $countones(byte_in));
  assign win_low = zsum < ZW'(AIS_ZMIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt     <= '0;
      zacc     <= '0;
      low_run  <= 1'b0;
      ts16_ais <= 1'b0;
    end else if (tick) begin
      wcnt <= wcnt + 1'b1;
      if (wcnt == IW'(MF_LEN - 1)) begin
        zacc     <= '0;
        low_run  <= win_low;
        ts16_ais <= win_low && low_run;
      end else begin
        zacc <= win_low ? zsum : ZW'(AIS_ZMIN);
      end
    end
  end

  // multiframe alignment, freeze, register file
  logic                    aligned, bad, prev_nz, frz, chg;
  logic [IW-1:0]           fcnt;
  logic [MF_LEN-1:0][7:0]  sig;
  logic                    wr, chg_set, chg_clr;

  assign wr      = tick && aligned && !frz && ((fcnt != '0) || mfas_ok);
  assign chg_set = wr && (fcnt != '0) && (sig[fcnt] != byte_in);
  assign chg_clr = rd_en && (rd_addr == 5'(MF_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned   <= 1'b0;
      bad       <= 1'b0;
      prev_nz   <= 1'b0;
      frz       <= 1'b1;
      fcnt      <= '0;
      rmf_alarm <= 1'b0;
      spare     <= '0;
    end else if (tick) begin
      prev_nz <= (byte_in != 8'h00);
      if (!aligned) begin
        if (prev_nz && mfas_ok) begin
          aligned   <= 1'b1;
          bad       <= 1'b0;
          fcnt      <= IW'(1);
          rmf_alarm <= byte_in[2];
          spare     <= {byte_in[3], byte_in[1], byte_in[0]};
        end
      end else begin
        fcnt <= fcnt + 1'b1;
        if (fcnt == '0) begin
          if (mfas_ok) begin
            bad       <= 1'b0;
            frz       <= 1'b0;
            rmf_alarm <= byte_in[2];
            spare     <= {byte_in[3], byte_in[1], byte_in[0]};
          end else if (bad) begin
            aligned <= 1'b0;
            frz     <= 1'b1;
            bad     <= 1'b0;
          end else begin
            bad <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
      chg <= 1'b0;
    end else begin
      if (wr) sig[fcnt] <= byte_in;
      chg <= chg_set || (chg && !chg_clr);
    end
  end

  assign mf_lost = !aligned;
  assign freeze  = frz;
  assign sig_irq = chg;

  always_comb begin
    if (rd_addr < 5'(MF_LEN))       rd_data = sig[rd_addr[IW-1:0]];
    else if (rd_addr == 5'(MF_LEN)) rd_data = {mf_lost, frz, ts16_ais, rmf_alarm, spare, chg};
    else                            rd_data = 8'h00;
  end

  AST_FREEZE_WHILE_LOST:   assert property (@(posedge clk) disable iff (!rst_n) !aligned |-> frz); // R7
  AST_FROZEN_REGS_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) frz |=> $stable(sig)); // R7
  AST_REGAIN_STAYS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(aligned) |-> frz); // R7
  AST_IRQ_NEEDS_CHANGE:    assert property (@(posedge clk) disable iff (!rst_n) $rose(chg) |-> !$stable(sig)); // R8
  AST_ONE_BAD_KEEPS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
                             (tick && aligned && fcnt == '0 && !mfas_ok && !bad) |=> aligned); // R4
endmodule

// File: tb/e1_cas_rx_bench.sv
module e1_cas_rx_bench;
  logic       clk = 0, rst_n = 0;
  logic       rx_en = 0, rx_fsync = 0, rx_bit = 0, rd_en = 0;
  logic [4:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       mf_lost, freeze, ts16_ais, rmf_alarm, sig_irq;
  logic [2:0] spare;

  int checks = 0, fails = 0, fc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_cas_rx u_e1_cas_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_fsync(rx_fsync), .rx_bit(rx_bit),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .mf_lost(mf_lost),
    .freeze(freeze), .ts16_ais(ts16_ais), .rmf_alarm(rmf_alarm), .spare(spare),
    .sig_irq(sig_irq));

  // {ts16 byte, expected lost, expected freeze}
  localparam logic [9:0] VEC [19] = '{
    {8'h00,1'b1,1'b1}, {8'hFF,1'b1,1'b1}, {8'h0B,1'b0,1'b1},
    {8'hA5,1'b0,1'b1}, {8'h3C,1'b0,1'b1}, {8'h96,1'b0,1'b1}, {8'h11,1'b0,1'b1},
    {8'h22,1'b0,1'b1}, {8'h33,1'b0,1'b1}, {8'h44,1'b0,1'b1}, {8'h55,1'b0,1'b1},
    {8'h66,1'b0,1'b1}, {8'h77,1'b0,1'b1}, {8'h88,1'b0,1'b1}, {8'h99,1'b0,1'b1},
    {8'hAA,1'b0,1'b1}, {8'hBB,1'b0,1'b1}, {8'hCC,1'b0,1'b1},
    {8'h0B,1'b0,1'b0}};

  function automatic logic [7:0] dat(int k);
    return {4'(k), 4'(15 - k)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic fill);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      rx_en    = 1;
      rx_fsync = (i == 0);
      rx_bit   = (i >= 128 && i <= 135) ? b[7 - (i - 128)] : fill;
    end
    @(negedge clk);
    rx_en = 0; rx_fsync = 0;
    fc++;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = 1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic send_mf(logic fill, int alt_k, logic [7:0] alt_v, logic [7:0] mfas);
    for (int k = 1; k < 16; k++) send((k == alt_k) ? alt_v : dat(k), fill);
    send(mfas, fill);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'd16, d); check("R10 status", d, 8'hC0);
    rd(5'd5, d);  check("R10 reg5", d, 8'h00);

    // R3 R7: table walk through regain and frozen multiframe
    for (int i = 0; i < 19; i++) begin
      send(VEC[i][9:2], i[0]);
      check("R3/R7 lost", {7'b0, mf_lost}, {7'b0, VEC[i][1]});
      check("R7 freeze", {7'b0, freeze}, {7'b0, VEC[i][0]});
    end
    rd(5'd3, d); check("R7 frozen data not stored", d, 8'h00);
    rd(5'd0, d); check("R7 reg0 frozen", d, 8'h00);
    check("R5 spare first", {5'b0, spare}, 8'h07);

    // R2 R5 R8: first stored multiframe
    send_mf(1'b1, 0, 8'h00, 8'h06);
    for (int k = 1; k < 16; k++) begin
      rd(5'(k), d); check("R2 reg", d, dat(k));
    end
    rd(5'd0, d); check("R2 reg0 mfas", d, 8'h06);
    check("R5 rmf", {7'b0, rmf_alarm}, 8'h01);
    check("R5 spare", {5'b0, spare}, 8'h02);
    rd(5'd16, d); check("R8 R9 status set", d, 8'h15);
    rd(5'd16, d); check("R8 cleared on read", d, 8'h14);

    // R1 R8: same content, other filler
    send_mf(1'b0, 0, 8'h00, 8'h06);
    rd(5'd16, d); check("R1 R8 no change", d, 8'h14);

    // R8: one channel pair changes
    send_mf(1'b1, 7, 8'h5A, 8'h06);
    rd(5'd7, d);  check("R8 reg7", d, 8'h5A);
    rd(5'd16, d); check("R8 change set", d, 8'h15);
    rd(5'd20, d); check("R9 unmapped", d, 8'h00);

    // R4: one bad word keeps alignment, second loses it
    send_mf(1'b0, 7, 8'h5A, 8'hF6);
    check("R4 one bad", {7'b0, mf_lost}, 8'h00);
    send_mf(1'b1, 7, 8'h5A, 8'hF6);
    check("R4 two bad", {7'b0, mf_lost}, 8'h01);
    check("R7 freeze on loss", {7'b0, freeze}, 8'h01);
    rd(5'd16, d); check("R9 status lost", d, 8'hD4);
    for (int i = 0; i < 4; i++) send(8'hEE, 1'b0);
    rd(5'd1, d); check("R7 hold while lost", d, dat(1));

    // R6: AIS windows
    do send(8'hF0, 1'b1); while (fc % 16 != 0);
    for (int i = 0; i < 16; i++) send(8'hFF, 1'b0);
    check("R6 one low window", {7'b0, ts16_ais}, 8'h00);
    for (int i = 0; i < 16; i++) send(8'hFF, 1'b1);
    check("R6 two low windows", {7'b0, ts16_ais}, 8'h01);
    check("R3 no align in AIS", {7'b0, mf_lost}, 8'h01);
    for (int i = 0; i < 16; i++) send(8'hF0, 1'b0);
    check("R6 clear", {7'b0, ts16_ais}, 8'h00);

    // R3: regain after non-zero byte
    send(8'h0B, 1'b1);
    check("R3 regain", {7'b0, mf_lost}, 8'h00);
    check("R7 frozen after regain", {7'b0, freeze}, 8'h01);

    finish_up();
  end
endmodule